// File: doc/BRIEF.md
# Target Write Burst Unloader

This controller sits on the user side of a bus target core. It takes in target write transactions and hands them to downstream logic. While idle it watches an active-low request line. When the line asserts, it pulses an address strobe for one cycle. In that cycle it latches the command code and the address that the core presents. It then enters a data phase and pops words from the head of the core's write FIFO with a data strobe. Each popped word goes downstream one cycle later, together with its 3-bit stage tag and a flag that marks the final word.

The core reports two FIFO flags. The empty flag is set when no entries remain. The low-water flag is set when four or fewer entries remain. The controller registers both flags, so its view of them is one cycle old. It pops back to back while that view shows plenty of data. When the registered low-water flag is set, it pops only every other cycle, and only while the registered empty flag is clear. This keeps the FIFO from ever being read past empty.

A burst ends when a popped word carries the active-low last indication. If the latched command is not a memory write, the header is marked as rejected. The burst is still drained from the FIFO, but its words are not forwarded.

Top module: `tw_burst_unloader`

## Requirements
- R1: After reset, addr_strobe, data_strobe, hdr_valid, hdr_reject and word_valid are all 0.
- R2: While idle, a low tgt_req_n sampled at a clock edge makes addr_strobe high in the cycle that follows. It stays high for exactly one cycle.
- R3: In the cycle after addr_strobe, hdr_valid is high for one cycle. hdr_addr and hdr_cmd then hold the core_addr and core_cmd values that were presented during the strobe cycle.
- R4: addr_strobe and data_strobe are never high in the same cycle. data_strobe can first go high in the cycle right after addr_strobe.
- R5: Each cycle with data_strobe high consumes exactly one FIFO head word. For an accepted command, that word appears on word_data one cycle later with word_valid high. Words are forwarded in FIFO order.
- R6: data_strobe is never high in a cycle when the fifo_empty value sampled at the previous edge was 1. The FIFO is never popped while it holds no entries.
- R7: If the fifo_low value sampled at the previous edge was 1, data_strobe is not high in two consecutive cycles. If that sampled value was 0, pops may come in consecutive cycles. With 20 words preloaded and no refill, the first run of consecutive pops is exactly 17 cycles long.
- R8: When a word is popped with core_last_n low, data_strobe is 0 in the next cycle and the controller is back in idle. A new request is then served with a fresh address strobe.
- R9: The only accepted command code is 4'b0111. Any other code sets hdr_reject together with hdr_valid. The burst's words are still popped, but word_valid stays 0 for them.
- R10: word_stage carries the core_stage value and word_last carries the inverse of core_last_n, both as they were in the cycle of the pop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tgt_req_n | input | 1 | Active-low target request from the core |
| core_addr | input | ADDR_W | Transaction address presented by the core |
| core_cmd | input | CMD_W | Transaction command code presented by the core |
| core_word | input | DATA_W | Write FIFO head word |
| core_stage | input | TAG_W | Stage tag of the head word |
| core_last_n | input | 1 | Active low: the head word ends the burst |
| fifo_empty | input | 1 | Write FIFO holds no entries |
| fifo_low | input | 1 | Write FIFO holds four or fewer entries |
| addr_strobe | output | 1 | Address/command enable toward the core |
| data_strobe | output | 1 | Pops the FIFO head at the end of the cycle |
| hdr_valid | output | 1 | One-cycle header pulse |
| hdr_addr | output | ADDR_W | Latched address |
| hdr_cmd | output | CMD_W | Latched command |
| hdr_reject | output | 1 | Latched command is not a memory write |
| word_valid | output | 1 | Forwarded word strobe |
| word_data | output | DATA_W | Forwarded data word |
| word_stage | output | TAG_W | Forwarded stage tag |
| word_last | output | 1 | Forwarded word ended the burst |

## Verification
The bench uses the default parameters: 32-bit address and data, a 4-bit command, a 3-bit tag, and the second write code disabled. With 32-bit words, every word can encode its own transaction and index, so a lost, repeated or reordered pop shows up directly as a data mismatch. The bench models a FIFO that updates its flags at the pop edge, as a real one does. That brings within reach the exact 17-cycle back-to-back run on a 20-word preload, the alternating pace below the low-water mark, and a slow producer that empties the FIFO mid-burst.

// File: rtl/twu_pkg.sv
package twu_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ADDR = 2'd1,
        ST_DATA = 2'd2
    } fsm_e;

    typedef struct packed {
        fsm_e st;
    } ctl_s;

    typedef struct packed {
        logic empty;
        logic low;
        logic popped;
    } pace_s;

endpackage

// File: rtl/twu_pacer.sv
// Registers the FIFO flags and decides whether a pop is safe this cycle.
module twu_pacer
    import twu_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic fifo_empty,
    input  logic fifo_low,
    input  logic pop,
    output logic may_pop
);

    pace_s pace_d, pace_q;

    always_comb begin
        pace_d        = pace_q;
        pace_d.empty  = fifo_empty;
        pace_d.low    = fifo_low;
        pace_d.popped = pop;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pace_q <= '{empty: 1'b1, low: 1'b1, popped: 1'b0};
        end else begin
            pace_q <= pace_d;
        end
    end

    // A clear low-water flag, sampled before the previous pop, still
    // leaves at least four entries. Otherwise pop only when the stale
    // empty flag was clear and no pop happened since it was sampled.
    assign may_pop = !pace_q.empty && (!pace_q.low || !pace_q.popped);

endmodule

// File: rtl/twu_hdr_capture.sv
// Latches command and address on the address strobe and classifies the command.
module twu_hdr_capture #(
    parameter int ADDR_W = 32,
    parameter int CMD_W  = 4,
    parameter logic [CMD_W-1:0] MEMWR_CODE = 4'b0111,
    parameter logic [CMD_W-1:0] MWI_CODE   = 4'b1111,
    parameter bit ACCEPT_MWI = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              capture,
    input  logic [ADDR_W-1:0] in_addr,
    input  logic [CMD_W-1:0]  in_cmd,
    output logic              hdr_valid,
    output logic [ADDR_W-1:0] hdr_addr,
    output logic [CMD_W-1:0]  hdr_cmd,
    output logic              hdr_reject,
    output logic              accept
);

    typedef struct packed {
        logic              valid;
        logic [ADDR_W-1:0] addr;
        logic [CMD_W-1:0]  cmd;
        logic              reject;
        logic              accept;
    } hdr_s;

    hdr_s hdr_d, hdr_q;
    logic code_ok;

    generate
        if (ACCEPT_MWI) begin : g_two_codes
            assign code_ok = (in_cmd == MEMWR_CODE) || (in_cmd == MWI_CODE);
        end else begin : g_one_code
            assign code_ok = (in_cmd == MEMWR_CODE);
        end
    endgenerate

    always_comb begin
        hdr_d       = hdr_q;
        hdr_d.valid = 1'b0;
        if (capture) begin
            hdr_d.valid  = 1'b1;
            hdr_d.addr   = in_addr;
            hdr_d.cmd    = in_cmd;
            hdr_d.reject = !code_ok;
            hdr_d.accept = code_ok;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hdr_q <= '0;
        end else begin
            hdr_q <= hdr_d;
        end
    end

    assign hdr_valid  = hdr_q.valid;
    assign hdr_addr   = hdr_q.addr;
    assign hdr_cmd    = hdr_q.cmd;
    assign hdr_reject = hdr_q.reject && hdr_q.valid;
    assign accept     = hdr_q.accept;

endmodule

// File: rtl/twu_word_fwd.sv
// Registers each popped word toward downstream logic when its burst is accepted.
module twu_word_fwd #(
    parameter int DATA_W = 32,
    parameter int TAG_W  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pop,
    input  logic              accept,
    input  logic [DATA_W-1:0] in_word,
    input  logic [TAG_W-1:0]  in_stage,
    input  logic              in_last_n,
    output logic              word_valid,
    output logic [DATA_W-1:0] word_data,
    output logic [TAG_W-1:0]  word_stage,
    output logic              word_last
);

    typedef struct packed {
        logic              valid;
        logic [DATA_W-1:0] data;
        logic [TAG_W-1:0]  stage;
        logic              last;
    } word_s;

    word_s word_d, word_q;

    always_comb begin
        word_d       = word_q;
        word_d.valid = 1'b0;
        if (pop && accept) begin
            word_d.valid = 1'b1;
            word_d.data  = in_word;
            word_d.stage = in_stage;
            word_d.last  = !in_last_n;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            word_q <= '0;
        end else begin
            word_q <= word_d;
        end
    end

    assign word_valid = word_q.valid;
    assign word_data  = word_q.data;
    assign word_stage = word_q.stage;
    assign word_last  = word_q.last;

endmodule

// File: rtl/tw_burst_unloader.sv
// Target write burst unloader: address phase, then paced FIFO unloading.
module tw_burst_unloader
    import twu_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int CMD_W  = 4,
    parameter int TAG_W  = 3,
    parameter logic [CMD_W-1:0] MEMWR_CODE = 4'b0111,
    parameter logic [CMD_W-1:0] MWI_CODE   = 4'b1111,
    parameter bit ACCEPT_MWI = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tgt_req_n,
    input  logic [ADDR_W-1:0] core_addr,
    input  logic [CMD_W-1:0]  core_cmd,
    input  logic [DATA_W-1:0] core_word,
    input  logic [TAG_W-1:0]  core_stage,
    input  logic              core_last_n,
    input  logic              fifo_empty,
    input  logic              fifo_low,
    output logic              addr_strobe,
    output logic              data_strobe,
    output logic              hdr_valid,
    output logic [ADDR_W-1:0] hdr_addr,
    output logic [CMD_W-1:0]  hdr_cmd,
    output logic              hdr_reject,
    output logic              word_valid,
    output logic [DATA_W-1:0] word_data,
    output logic [TAG_W-1:0]  word_stage,
    output logic              word_last
);

    ctl_s ctl_d, ctl_q;
    logic may_pop;
    logic accept;

    assign addr_strobe = (ctl_q.st == ST_ADDR);
    assign data_strobe = (ctl_q.st == ST_DATA) && may_pop;

    always_comb begin
        ctl_d = ctl_q;
        unique case (ctl_q.st)
            ST_IDLE: if (!tgt_req_n) ctl_d.st = ST_ADDR;
            ST_ADDR: ctl_d.st = ST_DATA;
            ST_DATA: if (data_strobe && !core_last_n) ctl_d.st = ST_IDLE;
            default: ctl_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= '{st: ST_IDLE};
        end else begin
            ctl_q <= ctl_d;
        end
    end

    twu_pacer u_pacer (
        .clk        (clk),
        .rst_n      (rst_n),
        .fifo_empty (fifo_empty),
        .fifo_low   (fifo_low),
        .pop        (data_strobe),
        .may_pop    (may_pop)
    );

    twu_hdr_capture #(
        .ADDR_W     (ADDR_W),
        .CMD_W      (CMD_W),
        .MEMWR_CODE (MEMWR_CODE),
        .MWI_CODE   (MWI_CODE),
        .ACCEPT_MWI (ACCEPT_MWI)
    ) u_hdr (
        .clk        (clk),
        .rst_n      (rst_n),
        .capture    (addr_strobe),
        .in_addr    (core_addr),
        .in_cmd     (core_cmd),
        .hdr_valid  (hdr_valid),
        .hdr_addr   (hdr_addr),
        .hdr_cmd    (hdr_cmd),
        .hdr_reject (hdr_reject),
        .accept     (accept)
    );

    twu_word_fwd #(
        .DATA_W (DATA_W),
        .TAG_W  (TAG_W)
    ) u_fwd (
        .clk        (clk),
        .rst_n      (rst_n),
        .pop        (data_strobe),
        .accept     (accept),
        .in_word    (core_word),
        .in_stage   (core_stage),
        .in_last_n  (core_last_n),
        .word_valid (word_valid),
        .word_data  (word_data),
        .word_stage (word_stage),
        .word_last  (word_last)
    );

endmodule

// File: rtl/twu_checker.sv
module twu_checker (
    input logic clk,
    input logic rst_n,
    input logic tgt_req_n,
    input logic core_last_n,
    input logic fifo_empty,
    input logic fifo_low,
    input logic addr_strobe,
    input logic data_strobe,
    input logic hdr_valid,
    input logic word_valid
);

    a_r2_addr_single: assert property (@(posedge clk) disable iff (!rst_n)
        addr_strobe |=> !addr_strobe);

    a_r2_addr_after_req: assert property (@(posedge clk) disable iff (!rst_n)
        addr_strobe |-> $past(!tgt_req_n));

    a_r3_hdr_follows_addr: assert property (@(posedge clk) disable iff (!rst_n)
        hdr_valid |-> $past(addr_strobe));

    a_r4_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
        !(addr_strobe && data_strobe));

    a_r5_word_follows_pop: assert property (@(posedge clk) disable iff (!rst_n)
        word_valid |-> $past(data_strobe));

    a_r6_no_pop_seen_empty: assert property (@(posedge clk) disable iff (!rst_n)
        data_strobe |-> !$past(fifo_empty));

    a_r7_spaced_when_low: assert property (@(posedge clk) disable iff (!rst_n)
        (data_strobe && $past(fifo_low)) |-> !$past(data_strobe));

    a_r8_stop_after_last: assert property (@(posedge clk) disable iff (!rst_n)
        (data_strobe && !core_last_n) |=> !data_strobe);

endmodule

bind tw_burst_unloader twu_checker u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .tgt_req_n   (tgt_req_n),
    .core_last_n (core_last_n),
    .fifo_empty  (fifo_empty),
    .fifo_low    (fifo_low),
    .addr_strobe (addr_strobe),
    .data_strobe (data_strobe),
    .hdr_valid   (hdr_valid),
    .word_valid  (word_valid)
);

// File: tb/tw_burst_unloader_tb.sv
`timescale 1ns/1ps
module tw_burst_unloader_tb;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        req_n;
    logic [31:0] c_addr;
    logic [3:0]  c_cmd;
    logic [31:0] c_word;
    logic [2:0]  c_stage;
    logic        c_last_n;
    logic        f_empty;
    logic        f_low;
    logic        addr_strobe, data_strobe, hdr_valid, hdr_reject, word_valid, word_last;
    logic [31:0] hdr_addr, word_data;
    logic [3:0]  hdr_cmd;
    logic [2:0]  word_stage;

    always #4 clk = ~clk;

    tw_burst_unloader u_dut (
        .clk(clk), .rst_n(rst_n), .tgt_req_n(req_n),
        .core_addr(c_addr), .core_cmd(c_cmd), .core_word(c_word),
        .core_stage(c_stage), .core_last_n(c_last_n),
        .fifo_empty(f_empty), .fifo_low(f_low),
        .addr_strobe(addr_strobe), .data_strobe(data_strobe),
        .hdr_valid(hdr_valid), .hdr_addr(hdr_addr), .hdr_cmd(hdr_cmd),
        .hdr_reject(hdr_reject), .word_valid(word_valid), .word_data(word_data),
        .word_stage(word_stage), .word_last(word_last)
    );

    int n_chk = 0;
    int n_fail = 0;

    function automatic void chk(input bit ok, input string req, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endfunction

    // FIFO model: entry = {last, stage[2:0], data[31:0]}
    logic [35:0] fifo[$];
    logic [35:0] exp_q[$];
    logic [35:0] ent, e;
    bit  pend = 0, hdr_pend = 0, last_pend = 0, tx_done = 0, accept_cur = 0;
    bit  smp_low = 1, smp_emp = 1, prev_ds = 0;
    int  pops = 0, nwords = 0, run = 0, max_run = 0;
    int  feed_left = 0, feed_period = 1, feed_cnt = 0, gen_idx = 0, gen_tot = 0;
    logic [7:0] tx_id = 0;

    function automatic void refresh();
        logic [35:0] h;
        h = (fifo.size() != 0) ? fifo[0] : 36'h0;
        f_empty  = (fifo.size() == 0);
        f_low    = (fifo.size() <= 4);
        c_word   = h[31:0];
        c_stage  = h[34:32];
        c_last_n = (fifo.size() != 0) ? !h[35] : 1'b1;
    endfunction

    function automatic void gen_push();
        logic [15:0] idx;
        idx = 16'(gen_idx);
        fifo.push_back({(gen_idx == gen_tot - 1), idx[2:0] ^ tx_id[2:0], 8'hA5, tx_id, idx});
        gen_idx++;
    endfunction

    // Pop at the edge that consumes the head, as a real FIFO would.
    always @(posedge clk) begin
        smp_low = f_low;
        smp_emp = f_empty;
        #1;
        if (pend) begin
            pend = 0;
            if (fifo.size() == 0) begin
                chk(1'b0, "R6 overread", 0, 1);
            end else begin
                ent = fifo.pop_front();
                pops++;
                if (accept_cur) exp_q.push_back(ent);
            end
            refresh();
        end
    end

    // Monitor and producer, mid-cycle.
    always @(negedge clk) begin
        if (rst_n) begin
            if (last_pend) begin
                last_pend = 0;
                chk(!data_strobe && !addr_strobe, "R8 idle after last", {data_strobe, addr_strobe}, 0);
                tx_done = 1;
            end
            if (word_valid) begin
                nwords++;
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R5 unexpected word", 1, 0);
                end else begin
                    e = exp_q.pop_front();
                    chk(word_data == e[31:0], "R5 data", word_data, e[31:0]);
                    chk(word_stage == e[34:32], "R10 stage", word_stage, e[34:32]);
                    chk(word_last == e[35], "R10 last", word_last, e[35]);
                end
            end
            if (hdr_pend) begin
                hdr_pend = 0;
                chk(hdr_valid, "R3 hdr_valid", hdr_valid, 1);
                chk(hdr_addr == c_addr, "R3 addr", hdr_addr, c_addr);
                chk(hdr_cmd == c_cmd, "R3 cmd", hdr_cmd, c_cmd);
                chk(hdr_reject == !accept_cur, "R9 reject", hdr_reject, !accept_cur);
            end else if (hdr_valid) begin
                chk(1'b0, "R3 stray hdr_valid", 1, 0);
            end
            if (addr_strobe) begin
                hdr_pend = 1;
                if (data_strobe) chk(1'b0, "R4 overlap", 1, 0);
            end
            if (data_strobe) begin
                pend = 1;
                if (smp_emp) chk(1'b0, "R6 pop on seen empty", 1, 0);
                if (smp_low && prev_ds) chk(1'b0, "R7 back-to-back below low mark", 1, 0);
                if (!c_last_n) begin
                    last_pend = 1;
                    req_n = 1'b1;
                end
                run++;
                if (run > max_run) max_run = run;
            end else begin
                run = 0;
            end
            prev_ds = data_strobe;
            if (feed_left > 0) begin
                if (feed_cnt == 0) begin
                    gen_push();
                    feed_left--;
                    feed_cnt = feed_period - 1;
                end else begin
                    feed_cnt--;
                end
            end
            refresh();
        end
    end

    task automatic run_tx(input logic [31:0] addr, input logic [3:0] cmd, input int n_pre,
                          input int n_total, input int period, input bit acc);
        int w0;
        @(negedge clk); #1;
        tx_id++;
        gen_idx = 0; gen_tot = n_total;
        for (int i = 0; i < n_pre; i++) gen_push();
        feed_left = n_total - n_pre; feed_period = period; feed_cnt = period - 1;
        accept_cur = acc; c_addr = addr; c_cmd = cmd;
        pops = 0; max_run = 0; tx_done = 0;
        w0 = nwords;
        refresh();
        req_n = 1'b0;
        @(negedge clk);
        chk(addr_strobe, "R2 strobe one cycle after request", addr_strobe, 1);
        @(negedge clk);
        chk(!addr_strobe, "R2 strobe lasts one cycle", addr_strobe, 0);
        for (int i = 0; i < 400 && !tx_done; i++) @(negedge clk);
        chk(tx_done, "R8 burst finished", tx_done, 1);
        chk(pops == n_total, "R5 words popped", pops, n_total);
        chk(fifo.size() == 0, "R6 fifo drained", fifo.size(), 0);
        chk(exp_q.size() == 0, "R5 all words forwarded", exp_q.size(), 0);
        chk(nwords - w0 == (acc ? n_total : 0), "R9 forwarded count", nwords - w0, acc ? n_total : 0);
    endtask

    task automatic t_reset();
        chk(!addr_strobe && !data_strobe && !hdr_valid && !hdr_reject && !word_valid,
            "R1 reset outputs", {addr_strobe, data_strobe, hdr_valid, hdr_reject, word_valid}, 0);
        repeat (3) @(negedge clk);
        chk(!addr_strobe, "R2 no strobe without request", addr_strobe, 0);
    endtask

    task automatic t_short();
        run_tx(32'h1000_0040, 4'b0111, 3, 3, 1, 1'b1);
        chk(max_run == 1, "R7 paced below low mark", max_run, 1);
    endtask

    task automatic t_long();
        run_tx(32'h2000_0100, 4'b0111, 20, 20, 1, 1'b1);
        chk(max_run == 17, "R7 back-to-back run", max_run, 17);
    endtask

    task automatic t_trickle();
        run_tx(32'h3000_0000, 4'b0111, 0, 6, 3, 1'b1);
    endtask

    task automatic t_reject();
        run_tx(32'h4000_0008, 4'b0011, 4, 4, 1, 1'b0);
    endtask

    task automatic t_back_to_back();
        run_tx(32'h5000_0000, 4'b0111, 6, 9, 2, 1'b1);
        run_tx(32'h5000_1000, 4'b0111, 2, 2, 1, 1'b1);
    endtask

    initial begin
        rst_n = 1'b0; req_n = 1'b1; c_addr = '0; c_cmd = '0;
        refresh();
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_short();
        t_long();
        t_trickle();
        t_reject();
        t_back_to_back();
        repeat (4) @(negedge clk);
        chk(!word_valid && !data_strobe, "R8 quiet after bursts", {word_valid, data_strobe}, 0);
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

endmodule